// File: doc/BRIEF.md
# Handshake Channel Endpoint Pair

This block carries one data item at a time from a producer to a consumer over a point-to-point link. The link has a request wire, an acknowledge wire and a data bus. A sender endpoint drives request and data. A receiver endpoint drives acknowledge. Both endpoints run on one clock, and every change on the link, on the user outputs and on the status takes effect at a rising clock edge.

A parameter selects the link signalling. Two-phase transition signalling is the default: each item costs one toggle of request and one toggle of acknowledge, and neither wire returns to zero. Four-phase return-to-zero signalling is the other choice: request and acknowledge each rise and then fall for every item. The producer offers an item with a valid/ready pair. The consumer asks for an item with a receive request and gets a one-cycle delivery strobe.

While an item is offered and not yet taken, the consumer can look at it through a peek output without acknowledging it. A status output and a busy flag show whether the channel is idle, whether the receiver is waiting for an item, or whether the sender is waiting for a taker.

Top module: `hs_channel`

## Requirements
- R1: After reset, link_req and link_ack are 0, snd_ready is 1, rcv_valid is 0, chan_state is 0 (idle) and chan_busy is 0.
- R2: An offer is taken at a rising edge where snd_valid and snd_ready are both 1. snd_ready then stays 0 until the handshake for that item has completed, and snd_valid has no effect while snd_ready is 0.
- R3: link_data holds the accepted item unchanged from the edge that raises or toggles link_req until the sender is ready again.
- R4: With PROTO set to four-phase (1), each item runs this sequence: link_req rises, link_ack rises, link_req falls, link_ack falls, and only then does snd_ready return to 1. link_ack rises only while link_req is 1, and link_req falls only while link_ack is 1.
- R5: With PROTO set to two-phase (0, the default), each item toggles link_req once and then link_ack once, and both wires keep their new levels afterwards. link_ack changes only when the two wires differ.
- R6: chan_state encodes 0 = idle, 1 = receiver waiting and 2 = sender waiting. The value 3 never occurs. An offered item that is not yet acknowledged reports 2, even while the receiver is also waiting.
- R7: While chan_state is 2, peek_valid is 1 and peek_data shows the offered item. Peeking leaves link_ack and chan_state unchanged.
- R8: chan_busy is 1 exactly when chan_state is not 0.
- R9: rcv_req is acted on only when the receiver is idle. Each delivery is a rcv_valid pulse of one cycle, with the item on rcv_data, and it follows a cycle in which chan_state was 2.
- R10: In both protocols, every accepted item is delivered exactly once and in order, for any pattern of stalls on either side.
- R11: If the receiver is already waiting when an item is accepted, rcv_valid is 1 in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| snd_valid | input | 1 | Producer offers snd_data |
| snd_data | input | WIDTH | Item to send |
| snd_ready | output | 1 | Sender endpoint can accept an item |
| rcv_req | input | 1 | Consumer asks for one item |
| rcv_valid | output | 1 | One-cycle delivery strobe |
| rcv_data | output | WIDTH | Delivered item |
| peek_valid | output | 1 | An offered item can be inspected |
| peek_data | output | WIDTH | Offered item, not yet acknowledged |
| chan_state | output | 2 | 0 idle, 1 receiver waiting, 2 sender waiting |
| chan_busy | output | 1 | Channel is not idle |
| link_req | output | 1 | Request wire of the link |
| link_ack | output | 1 | Acknowledge wire of the link |
| link_data | output | WIDTH | Data bus of the link |

## Verification
The assertions assume that rst_n is held low from time zero through at least one rising edge, and that only the two endpoints drive the link wires. They place no limit on how snd_valid and rcv_req behave. The stimulus holds reset from the start and changes every input only at falling edges. It sends random offers and random receive requests to one instance of each protocol, so refused offers and repeated requests while the receiver is busy occur often, and every input value is legal.

// File: rtl/hs_chan_pkg.sv
package hs_chan_pkg;

   typedef enum logic [1:0] {
      CH_IDLE    = 2'd0,
      CH_RX_WAIT = 2'd1,
      CH_TX_WAIT = 2'd2
   } chan_state_e;

   typedef enum logic {
      HS_TWO_PHASE  = 1'b0,
      HS_FOUR_PHASE = 1'b1
   } hs_proto_e;

   localparam int STATE_W = 2;

endpackage

// File: rtl/hs_tx.sv
module hs_tx #(
   parameter int                    WIDTH = 8,
   parameter hs_chan_pkg::hs_proto_e PROTO = hs_chan_pkg::HS_TWO_PHASE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snd_valid,
   input  logic [WIDTH-1:0] snd_data,
   output logic             snd_ready,
   input  logic             link_ack,
   output logic             link_req,
   output logic [WIDTH-1:0] link_data
);

   logic [WIDTH-1:0] data_q;
   assign link_data = data_q;

   if (PROTO == hs_chan_pkg::HS_FOUR_PHASE) begin : g_four
      typedef enum logic [1:0] {TX_IDLE, TX_RAISED, TX_DROPPED} tx_st_e;
      tx_st_e st_q;
      logic   req_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q   <= TX_IDLE;
            req_q  <= 1'b0;
            data_q <= '0;
         end else begin
            case (st_q)
               TX_IDLE: if (snd_valid) begin
                  data_q <= snd_data;
                  req_q  <= 1'b1;
                  st_q   <= TX_RAISED;
               end
               TX_RAISED: if (link_ack) begin
                  req_q <= 1'b0;
                  st_q  <= TX_DROPPED;
               end
               TX_DROPPED: if (!link_ack) st_q <= TX_IDLE;
               default: st_q <= TX_IDLE;
            endcase
         end
      end

      assign snd_ready = (st_q == TX_IDLE);
      assign link_req  = req_q;
   end else begin : g_two
      logic busy_q;
      logic phase_q;
      logic req_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b1;
            req_q   <= 1'b0;
            data_q  <= '0;
         end else if (!busy_q) begin
            if (snd_valid) begin
               data_q <= snd_data;
               req_q  <= phase_q;
               busy_q <= 1'b1;
            end
         end else if (link_ack == phase_q) begin
            phase_q <= ~phase_q;
            busy_q  <= 1'b0;
         end
      end

      assign snd_ready = !busy_q;
      assign link_req  = req_q;
   end

endmodule

// File: rtl/hs_rx.sv
module hs_rx #(
   parameter int                    WIDTH = 8,
   parameter hs_chan_pkg::hs_proto_e PROTO = hs_chan_pkg::HS_TWO_PHASE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rcv_req,
   input  logic             link_req,
   input  logic [WIDTH-1:0] link_data,
   output logic             link_ack,
   output logic             rcv_valid,
   output logic [WIDTH-1:0] rcv_data,
   output logic             rx_waiting
);

   logic [WIDTH-1:0] cap_q;
   logic             vld_q;
   logic             ack_q;

   assign rcv_data  = cap_q;
   assign rcv_valid = vld_q;
   assign link_ack  = ack_q;

   if (PROTO == hs_chan_pkg::HS_FOUR_PHASE) begin : g_four
      typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_HOLD} rx_st_e;
      rx_st_e st_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q  <= RX_IDLE;
            ack_q <= 1'b0;
            vld_q <= 1'b0;
            cap_q <= '0;
         end else begin
            vld_q <= 1'b0;
            case (st_q)
               RX_IDLE: if (rcv_req) st_q <= RX_WAIT;
               RX_WAIT: if (link_req) begin
                  cap_q <= link_data;
                  ack_q <= 1'b1;
                  vld_q <= 1'b1;
                  st_q  <= RX_HOLD;
               end
               RX_HOLD: if (!link_req) begin
                  ack_q <= 1'b0;
                  st_q  <= RX_IDLE;
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end

      assign rx_waiting = (st_q == RX_WAIT);
   end else begin : g_two
      logic wait_q;
      logic phase_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wait_q  <= 1'b0;
            phase_q <= 1'b1;
            ack_q   <= 1'b0;
            vld_q   <= 1'b0;
            cap_q   <= '0;
         end else begin
            vld_q <= 1'b0;
            if (!wait_q) begin
               if (rcv_req) wait_q <= 1'b1;
            end else if (link_req == phase_q) begin
               cap_q   <= link_data;
               ack_q   <= phase_q;
               phase_q <= ~phase_q;
               vld_q   <= 1'b1;
               wait_q  <= 1'b0;
            end
         end
      end

      assign rx_waiting = wait_q;
   end

endmodule

// File: rtl/hs_status.sv
module hs_status #(
   parameter hs_chan_pkg::hs_proto_e PROTO = hs_chan_pkg::HS_TWO_PHASE
) (
   input  logic                            link_req,
   input  logic                            link_ack,
   input  logic                            rx_waiting,
   output logic [hs_chan_pkg::STATE_W-1:0] chan_state,
   output logic                            chan_busy
);

   logic offered;

   if (PROTO == hs_chan_pkg::HS_FOUR_PHASE) begin : g_four
      assign offered = link_req & ~link_ack;
   end else begin : g_two
      assign offered = link_req ^ link_ack;
   end

   hs_chan_pkg::chan_state_e st;

   always_comb begin
      if (offered)         st = hs_chan_pkg::CH_TX_WAIT;
      else if (rx_waiting) st = hs_chan_pkg::CH_RX_WAIT;
      else                 st = hs_chan_pkg::CH_IDLE;
   end

   assign chan_state = st;
   assign chan_busy  = (st != hs_chan_pkg::CH_IDLE);

endmodule

// File: rtl/hs_channel.sv
module hs_channel #(
   parameter int                    WIDTH = 8,
   parameter hs_chan_pkg::hs_proto_e PROTO = hs_chan_pkg::HS_TWO_PHASE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snd_valid,
   input  logic [WIDTH-1:0] snd_data,
   output logic             snd_ready,
   input  logic             rcv_req,
   output logic             rcv_valid,
   output logic [WIDTH-1:0] rcv_data,
   output logic             peek_valid,
   output logic [WIDTH-1:0] peek_data,
   output logic [1:0]       chan_state,
   output logic             chan_busy,
   output logic             link_req,
   output logic             link_ack,
   output logic [WIDTH-1:0] link_data
);

   if (WIDTH < 1) begin : g_bad_width
      $error("hs_channel: WIDTH must be at least 1");
   end
   if (hs_chan_pkg::STATE_W != 2) begin : g_bad_state_w
      $error("hs_channel: status encoding must be two bits wide");
   end

   logic rx_waiting;

   hs_tx #(.WIDTH(WIDTH), .PROTO(PROTO)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .snd_valid (snd_valid),
      .snd_data  (snd_data),
      .snd_ready (snd_ready),
      .link_ack  (link_ack),
      .link_req  (link_req),
      .link_data (link_data)
   );

   hs_rx #(.WIDTH(WIDTH), .PROTO(PROTO)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rcv_req    (rcv_req),
      .link_req   (link_req),
      .link_data  (link_data),
      .link_ack   (link_ack),
      .rcv_valid  (rcv_valid),
      .rcv_data   (rcv_data),
      .rx_waiting (rx_waiting)
   );

   hs_status #(.PROTO(PROTO)) u_status (
      .link_req   (link_req),
      .link_ack   (link_ack),
      .rx_waiting (rx_waiting),
      .chan_state (chan_state),
      .chan_busy  (chan_busy)
   );

   assign peek_valid = (chan_state == hs_chan_pkg::CH_TX_WAIT);
   assign peek_data  = link_data;

endmodule

// File: rtl/hs_channel_chk.sv
module hs_channel_chk #(
   parameter int                    WIDTH = 8,
   parameter hs_chan_pkg::hs_proto_e PROTO = hs_chan_pkg::HS_TWO_PHASE
) (
   input logic             clk,
   input logic             rst_n,
   input logic             snd_valid,
   input logic             snd_ready,
   input logic             rcv_valid,
   input logic [1:0]       chan_state,
   input logic             link_req,
   input logic             link_ack,
   input logic [WIDTH-1:0] link_data
);

   assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && snd_ready) |=> !snd_ready);

   assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!snd_ready && $past(!snd_ready)) |-> $stable(link_data));

   if (PROTO == hs_chan_pkg::HS_FOUR_PHASE) begin : g_four
      assert_ack_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(link_ack) |-> link_req);
      assert_req_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(link_req) |-> link_ack);
   end else begin : g_two
      assert_ack_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (link_ack != $past(link_ack)) |-> $past(link_req != link_ack));
   end

   assert_state_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_state != 2'd3);

   assert_deliver_after_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rcv_valid |-> ($past(chan_state) == 2'd2));

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rcv_valid |=> !rcv_valid);

endmodule

bind hs_channel hs_channel_chk #(.WIDTH(WIDTH), .PROTO(PROTO)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .snd_valid  (snd_valid),
   .snd_ready  (snd_ready),
   .rcv_valid  (rcv_valid),
   .chan_state (chan_state),
   .link_req   (link_req),
   .link_ack   (link_ack),
   .link_data  (link_data)
);

// File: tb/hs_channel_test.sv
`timescale 1ns/1ps
module hs_channel_test;

   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic         sv_a = 0, rq_a = 0, rdy_a, rv_a, pv_a, busy_a, lr_a, la_a;
   logic [W-1:0] sd_a = '0, rd_a, pd_a, ld_a;
   logic [1:0]   st_a;
   logic         sv_b = 0, rq_b = 0, rdy_b, rv_b, pv_b, busy_b, lr_b, la_b;
   logic [W-1:0] sd_b = '0, rd_b, pd_b, ld_b;
   logic [1:0]   st_b;

   hs_channel #(.WIDTH(W), .PROTO(hs_chan_pkg::HS_TWO_PHASE)) uut (
      .clk(clk), .rst_n(rst_n), .snd_valid(sv_a), .snd_data(sd_a), .snd_ready(rdy_a),
      .rcv_req(rq_a), .rcv_valid(rv_a), .rcv_data(rd_a), .peek_valid(pv_a),
      .peek_data(pd_a), .chan_state(st_a), .chan_busy(busy_a), .link_req(lr_a),
      .link_ack(la_a), .link_data(ld_a));

   hs_channel #(.WIDTH(W), .PROTO(hs_chan_pkg::HS_FOUR_PHASE)) uut_4ph (
      .clk(clk), .rst_n(rst_n), .snd_valid(sv_b), .snd_data(sd_b), .snd_ready(rdy_b),
      .rcv_req(rq_b), .rcv_valid(rv_b), .rcv_data(rd_b), .peek_valid(pv_b),
      .peek_data(pd_b), .chan_state(st_b), .chan_busy(busy_b), .link_req(lr_b),
      .link_ack(la_b), .link_data(ld_b));

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [W-1:0] q_a[$];
   logic [W-1:0] q_b[$];

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected next item of a scoreboard, or -1 when nothing is outstanding
   function automatic int head_of(input logic [W-1:0] q[$]);
      if (q.size() == 0) return -1;
      return int'(q[0]);
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 state", st_a, 0);  chk("R1 req", lr_a, 0);   chk("R1 ack", la_a, 0);
      chk("R1 ready", rdy_a, 1); chk("R1 rcv_valid", rv_a, 0); chk("R1 busy", busy_a, 0);
      chk("R1 ready 4ph", rdy_b, 1); chk("R1 state 4ph", st_b, 0);

      // two-phase: offer with no taker, peek, refused second offer
      sv_a = 1; sd_a = 8'h5A; step();
      sd_a = 8'h11;
      chk("R2 ready low", rdy_a, 0);  chk("R6 tx wait", st_a, 2);
      chk("R7 peek valid", pv_a, 1);  chk("R7 peek data", pd_a, 8'h5A);
      chk("R8 busy", busy_a, 1);      chk("R5 req toggled", lr_a, 1);
      step(); step();
      chk("R2 refused offer", ld_a, 8'h5A); chk("R3 data held", pd_a, 8'h5A);
      chk("R7 no ack", la_a, 0);            chk("R7 state kept", st_a, 2);
      sv_a = 0; rq_a = 1; step(); rq_a = 0;
      chk("R6 priority", st_a, 2); chk("R9 not yet", rv_a, 0);
      step();
      chk("R9 valid", rv_a, 1); chk("R9 data", rd_a, 8'h5A);
      chk("R5 ack toggled", la_a, 1); chk("R2 still busy", rdy_a, 0);
      step();
      chk("R2 ready again", rdy_a, 1); chk("R9 pulse", rv_a, 0);
      chk("R5 req level kept", lr_a, 1); chk("R5 ack level kept", la_a, 1);
      chk("R6 idle", st_a, 0);
      rq_a = 1; step(); rq_a = 0;
      chk("R6 rx wait", st_a, 1); chk("R8 busy rx", busy_a, 1); chk("R7 no peek", pv_a, 0);
      sv_a = 1; sd_a = 8'hC3; step(); sv_a = 0;
      chk("R11 not early", rv_a, 0); chk("R5 req back", lr_a, 0);
      step();
      chk("R11 valid", rv_a, 1); chk("R11 data", rd_a, 8'hC3); chk("R5 ack back", la_a, 0);

      // four-phase sequence
      rq_b = 1; step(); rq_b = 0;
      chk("R6 rx wait 4ph", st_b, 1);
      sv_b = 1; sd_b = 8'h3C; step(); sv_b = 0;
      chk("R4 req up", lr_b, 1); chk("R4 ack low", la_b, 0); chk("R6 tx wait 4ph", st_b, 2);
      step();
      chk("R4 ack up", la_b, 1); chk("R4 req held", lr_b, 1);
      chk("R11 valid 4ph", rv_b, 1); chk("R11 data 4ph", rd_b, 8'h3C);
      step();
      chk("R4 req down", lr_b, 0); chk("R4 ack held", la_b, 1); chk("R4 not ready", rdy_b, 0);
      step();
      chk("R4 ack down", la_b, 0); chk("R4 not ready yet", rdy_b, 0);
      step();
      chk("R4 ready", rdy_b, 1); chk("R8 idle 4ph", busy_b, 0);

      // random stalls on both sides, both protocols
      for (int cyc = 0; cyc < 4000; cyc++) begin
         if (rv_a) begin chk("R10 order 2ph", rd_a, head_of(q_a)); if (q_a.size() > 0) void'(q_a.pop_front()); end
         if (rv_b) begin chk("R10 order 4ph", rd_b, head_of(q_b)); if (q_b.size() > 0) void'(q_b.pop_front()); end
         sv_a = ($urandom % 3) != 0; sd_a = W'($urandom);
         sv_b = ($urandom % 2) != 0; sd_b = W'($urandom);
         rq_a = ($urandom % 4) == 0; rq_b = ($urandom % 2) == 0;
         if (sv_a && rdy_a) q_a.push_back(sd_a);
         if (sv_b && rdy_b) q_b.push_back(sd_b);
         step();
      end
      sv_a = 0; sv_b = 0; rq_a = 1; rq_b = 1;
      for (int cyc = 0; cyc < 60; cyc++) begin
         if (rv_a) begin chk("R10 order 2ph", rd_a, head_of(q_a)); if (q_a.size() > 0) void'(q_a.pop_front()); end
         if (rv_b) begin chk("R10 order 4ph", rd_b, head_of(q_b)); if (q_b.size() > 0) void'(q_b.pop_front()); end
         step();
      end
      chk("R10 none lost 2ph", q_a.size(), 0);
      chk("R10 none lost 4ph", q_b.size(), 0);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule